// File: doc/BRIEF.md
# SDRAM Refresh Interval Timer

This block paces the refresh traffic of an SDRAM controller. A free-running prescaler derives a slow tick from the system clock. A 3-bit rate select picks the tick period from a fixed set of power-of-two divisors. On each tick a 16-bit interval counter either steps up by one or, if it already equals a 16-bit limit register, returns to zero and raises a refresh request. The command sequencer that issues the refresh takes that request over a valid/ready handshake.

Software reaches the rate select, the counter, the limit and a small status word through a flat register port. Writes are synchronous. Reads are combinational on the address. A sticky match flag records every compare event and can drive an interrupt line. A sticky overflow bit records a compare event that arrives while an earlier request is still waiting.

The request output follows valid/ready rules. Once `ref_valid` rises, it holds until a clock edge where `ref_ready` is high. A held request is never dropped and never duplicated. Back-pressure from the sequencer does not stall the counter. Further compare events during the wait are folded into the one pending request and reported through the overflow bit.

Top module: `refresh_timer`

## Requirements
- R1: After reset, the control word, the counter and the limit all read 0, `ref_valid` is 0 and `irq` is 0.
- R2: While the rate select is 0, the counter holds its value and the prescaler is held at its start phase. A counter written in this state reads back unchanged later.
- R3: Rate select values 1..7 give a tick period D of 4, 16, 64, 256, 1024, 2048 and 4096 cycles. When the select is written from 0 at clock edge E, the counter first advances at edge E+D and then at every D edges after that.
- R4: On a tick where the counter equals the limit, the counter becomes 0 and `ref_valid` rises at that same edge. Starting from 0 with limit N, requests rise at edges E+D*(N+1), E+2*D*(N+1), and so on.
- R5: Selecting a nonzero rate resumes counting from the counter's present value. With count C and limit N (C <= N), the first request rises at edge E+D*(N-C+1).
- R6: Control word bit 4 is a sticky match flag, set by every compare event. Writing 0 to bit 4 clears it and writing 1 leaves it unchanged. `irq` equals the flag ANDed with the interrupt enable in bit 3.
- R7: `ref_valid` stays high until an edge where `ref_ready` is high. It falls at that edge unless a new compare event occurs on the same edge.
- R8: A compare event while `ref_valid` is high and `ref_ready` is low sets the overflow bit, control word bit 5. It clears only when 0 is written to that bit.
- R9: A write to the counter register overrides both the increment and the compare-clear on the same edge. The counter takes the written value, and that tick raises no request and no flag.
- R10: Register addresses are 0 for the control word (bits 2:0 rate select, bit 3 interrupt enable, bit 4 match flag, bit 5 overflow), 1 for the counter and 2 for the limit. Address 3 reads 0, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ref_valid | output | 1 | Refresh request pending |
| ref_ready | input | 1 | Sequencer accepts the request |
| irq | output | 1 | Match interrupt |

## Verification
Two things can land on the same clock edge. A software write to the counter can coincide with the tick on which the counter would match the limit. A new compare event can also arrive while an earlier request is still held. The bench computes the exact match edge from the rate and limit and places a counter write on that edge. It expects the written value to read back, and it expects no request and no match flag. Separately, the bench withholds `ref_ready` with a limit of 0 so that every tick matches. It then expects `ref_valid` to stay high, the overflow bit to set, and neither to clear until software and the sequencer act.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int SEL_W = 3;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_LIMIT = 2'd2;

  localparam int B_IEN  = 3;
  localparam int B_FLAG = 4;
  localparam int B_OVF  = 5;

  // log2 of the tick divisor for each rate select; 0 means stopped
  function automatic int tap_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      3'd6:    return 11;
      3'd7:    return 12;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler
  import rt_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;
  logic             running;

  assign running = (sel != '0);

  // mask covers the low tap_shift(sel) bits
  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < tap_shift(sel)) mask[i] = 1'b1;
    end
  end

  assign tick = running && ((div_q & mask) == mask);

  // held at zero while stopped so the first interval after a start is full length
  always_ff @(posedge clk) begin
    if (!rst_n)        div_q <= '0;
    else if (!running) div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end

  p_phase_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> (div_q == '0));
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  // a software write claims this tick entirely
  assign match = tick && !wr_en && (count == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (wr_en) count <= wr_data;
    else if (match) count <= '0;
    else if (tick)  count <= count + 1'b1;
  end

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data)));

  p_clear_on_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (count == '0));

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(count));
endmodule

// File: rtl/rt_req_ctrl.sv
module rt_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic ready,
  output logic valid,
  output logic ovf_set
);
  // a compare event landing on an unaccepted request is folded in and reported
  assign ovf_set = match && valid && !ready;

  always_ff @(posedge clk) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= (valid && !ready) || match;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid);

  p_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> valid);
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import rt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             ref_valid,
  input  logic             ref_ready,
  output logic             irq
);
  logic [SEL_W-1:0] sel_q;
  logic             ien_q, flag_q, ovf_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] ctrl_word;
  logic             tick, match, ovf_set;
  logic             wr_ctrl, wr_count, wr_limit;

  assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
  assign wr_count = reg_we && (reg_addr == A_COUNT);
  assign wr_limit = reg_we && (reg_addr == A_LIMIT);

  rt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .tick(tick)
  );

  rt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_count),
    .wr_data(reg_wdata), .limit(limit_q), .count(count), .match(match)
  );

  rt_req_ctrl u_req (
    .clk(clk), .rst_n(rst_n), .match(match), .ready(ref_ready),
    .valid(ref_valid), .ovf_set(ovf_set)
  );

  // hardware set beats a software clear on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      ien_q   <= 1'b0;
      flag_q  <= 1'b0;
      ovf_q   <= 1'b0;
      limit_q <= '0;
    end else begin
      if (wr_ctrl) begin
        sel_q <= reg_wdata[SEL_W-1:0];
        ien_q <= reg_wdata[B_IEN];
      end
      if (match)                             flag_q <= 1'b1;
      else if (wr_ctrl && !reg_wdata[B_FLAG]) flag_q <= 1'b0;
      if (ovf_set)                           ovf_q <= 1'b1;
      else if (wr_ctrl && !reg_wdata[B_OVF])  ovf_q <= 1'b0;
      if (wr_limit) limit_q <= reg_wdata;
    end
  end

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[SEL_W-1:0]   = sel_q;
    ctrl_word[B_IEN]       = ien_q;
    ctrl_word[B_FLAG]      = flag_q;
    ctrl_word[B_OVF]       = ovf_q;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_word;
      A_COUNT: reg_rdata = count;
      A_LIMIT: reg_rdata = limit_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = flag_q && ien_q;

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_ctrl) |=> flag_q);

  p_match_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q);

  p_no_overflow_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_q);
endmodule

// File: tb/tb_refresh_timer.sv
module tb_refresh_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        ref_valid;
  logic        ref_ready = 1'b0;
  logic        irq;

  int cyc = 0;
  int nvec = 0;
  int nbad = 0;
  int last_edge = 0;
  bit ack_en = 1'b0;
  bit prev_valid = 1'b0;
  bit finished = 1'b0;
  int    exp_edge[$];
  string exp_tag[$];

  refresh_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ref_valid(ref_valid),
    .ref_ready(ref_ready), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (edge %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    #1;
    reg_we = 1'b0;
    last_edge = cyc;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] a, input int exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, int'(reg_rdata), exp);
  endtask

  // returns so that the next wr() lands on edge t
  task automatic align_edge(input int t);
    while (cyc < t - 2) @(negedge clk);
  endtask

  task automatic wait_edge(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic expect_req(input int e, input string tag);
    exp_edge.push_back(e);
    exp_tag.push_back(tag);
  endtask

  // monitor: compares each request rise against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (ref_valid && !prev_valid) begin
        if (exp_edge.size() == 0) begin
          check("R4 unexpected request", cyc, -1);
        end else begin
          check(exp_tag.pop_front(), cyc, exp_edge.pop_front());
        end
      end
      prev_valid = ref_valid;
      ref_ready = ack_en && ref_valid;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    int e0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R10 reset state and map
    rd_check("R1 ctrl", 2'd0, 0);
    rd_check("R1 count", 2'd1, 0);
    rd_check("R1 limit", 2'd2, 0);
    rd_check("R10 addr3", 2'd3, 0);
    check("R1 valid", int'(ref_valid), 0);
    check("R1 irq", int'(irq), 0);

    // R2 stopped counter holds
    wr(2'd2, 16'd2);
    repeat (40) @(negedge clk);
    rd_check("R2 stopped count", 2'd1, 0);

    // R3/R4 periodic requests, div 4, limit 3
    ack_en = 1'b1;
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0009);
    e0 = last_edge;
    expect_req(e0 + 16, "R4 first request");
    expect_req(e0 + 32, "R4 second request");
    wait_edge(e0 + 20);
    rd_check("R6 flag set", 2'd0, 32'h19);
    check("R6 irq high", int'(irq), 1);
    align_edge(e0 + 34);
    wr(2'd0, 16'h0008);
    rd_check("R6 flag cleared", 2'd0, 32'h08);
    check("R6 irq low", int'(irq), 0);
    wr(2'd0, 16'h0018);
    rd_check("R6 write one no effect", 2'd0, 32'h08);

    // R2 written value held while stopped
    wr(2'd1, 16'd9);
    repeat (40) @(negedge clk);
    rd_check("R2 held count", 2'd1, 9);

    // R5 resume from current value
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd9);
    wr(2'd0, 16'h0001);
    e0 = last_edge;
    expect_req(e0 + 20, "R5 resume request");
    align_edge(e0 + 22);
    wr(2'd0, 16'h0000);

    // R3 div 64, limit 1
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h0003);
    e0 = last_edge;
    expect_req(e0 + 128, "R3 div64 request");
    align_edge(e0 + 130);
    wr(2'd0, 16'h0000);

    // R3 div 4096, limit 0
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0007);
    e0 = last_edge;
    expect_req(e0 + 4096, "R3 div4096 request");
    align_edge(e0 + 4098);
    wr(2'd0, 16'h0000);

    // R7/R8 back-pressure: every tick matches, no ack
    ack_en = 1'b0;
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h0001);
    e0 = last_edge;
    expect_req(e0 + 4, "R7 held request");
    wait_edge(e0 + 6);
    check("R7 valid held", int'(ref_valid), 1);
    rd_check("R8 no overflow yet", 2'd0, 32'h11);
    wait_edge(e0 + 12);
    check("R7 valid still held", int'(ref_valid), 1);
    rd_check("R8 overflow set", 2'd0, 32'h31);
    wr(2'd0, 16'h0030);
    rd_check("R8 overflow sticky", 2'd0, 32'h30);
    wr(2'd0, 16'h0000);
    rd_check("R8 overflow cleared", 2'd0, 0);
    ack_en = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 accepted", int'(ref_valid), 0);

    // R9 counter write on the match edge
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0001);
    e0 = last_edge;
    align_edge(e0 + 16);
    wr(2'd1, 16'd7);
    rd_check("R9 written value", 2'd1, 7);
    repeat (6) @(negedge clk);
    rd_check("R9 no flag", 2'd0, 32'h01);
    wr(2'd0, 16'h0000);
    rd_check("R10 limit readback", 2'd2, 3);

    repeat (10) @(negedge clk);
    check("R4 all requests seen", exp_edge.size(), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule